// File: doc/BRIEF.md
# Vector Register Group Operand Locator

This unit sits beside the register file of a small vector core. It holds the current element-width and grouping settings, loaded through a write strobe. For each operand presented to it, it works out the effective element width and the effective group size that belong to the operand's role. It then turns an element index into the physical register that holds the element and the bit position where the element starts inside that register.

Register length is a build parameter and may be narrower than the widest element. In that case an element occupies several consecutive registers of its group. The unit raises a single illegal flag whenever any of the following holds:

- the operand specifier is reserved;
- the group cannot be formed;
- the element does not fit inside the group.

Top module: `vgrp_locator`

## Requirements
- R1: For the plain role (`op_role`=0), `eew_log` equals the stored width code and `emul_log` equals the stored group code. Width code w means 8·2^w bits: 0=8, 1=16, 2=32, 3=64. Group code g means 2^g registers.
- R2: For the widening-destination role (`op_role`=1) and the narrowing-source role (`op_role`=2), the effective width is twice the stored width and the effective group is twice the stored group. Both `eew_log` and `emul_log` are one above the stored codes.
- R3: For any legal operand, `eew_log` − `emul_log` equals the stored width code minus the stored group code, so every role sees the same element count.
- R4: `illegal` is set when the effective group would exceed 8 registers (`emul_log` > 3). It is also set when the effective width would exceed 64 bits (`eew_log` > 3).
- R5: `illegal` is set when `op_base` is not a multiple of the effective group size, or when `op_base` plus the group size exceeds 32.
- R6: For element index i with effective width E bits, let p = i·E. Then `reg_num` = `op_base` + floor(p / VLEN) and `bit_off` = p mod VLEN.
- R7: `illegal` is set when (i+1)·E exceeds the group size times VLEN. This means an element wider than one register is legal only when the group spans enough registers to hold it.
- R8: On reset the stored width code is 0 (8 bits) and the stored group code is 0 (one register). The codes load from `cfg_sew` and `cfg_lmul` on a clock edge where `cfg_we` is 1, and stay unchanged otherwise.
- R9: `illegal` is set for the reserved role `op_role`=3 and for stored group codes 4 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load strobe for the width and group codes |
| cfg_sew | input | 2 | Element width code to load |
| cfg_lmul | input | 3 | Group size code (log2) to load |
| op_role | input | 2 | Operand role: 0 plain, 1 widening destination, 2 narrowing source, 3 reserved |
| op_base | input | RW (5) | Lowest register of the operand's group |
| op_idx | input | IDXW (8) | Element index |
| eew_log | output | 3 | Effective width code (log2 of width/8) |
| emul_log | output | 3 | Effective group code (log2 of register count) |
| reg_num | output | RW (5) | Register holding the start of the element |
| bit_off | output | log2(VLEN) (5) | Bit offset of the element inside that register |
| illegal | output | 1 | Operand cannot be located as given |

## Verification
The assertions run on every cycle and check four things for any legal result:

- the width-to-group ratio is kept;
- effective codes stay within their limits;
- the base is aligned;
- the located register lies inside the group and the offset falls on an element boundary.

They also check that the stored codes change only on a strobe, and that reserved codes always raise the flag. The exact doubling per role, the register and offset values for chosen indices, and the boundary where an index first leaves the group can only be shown by the bench's scenarios. The same holds for the case of 64-bit elements spanning two 32-bit registers, and for ignored configuration inputs while the strobe is low.

// File: rtl/vgrp_locator.sv
module vgrp_locator #(
  parameter int VLEN = 32,
  parameter int NREG = 32,
  parameter int IDXW = 8,
  localparam int RW   = $clog2(NREG),
  localparam int VLOG = $clog2(VLEN),
  localparam int PW   = IDXW + VLOG + 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sew,
  input  logic [2:0]      cfg_lmul,
  input  logic [1:0]      op_role,
  input  logic [RW-1:0]   op_base,
  input  logic [IDXW-1:0] op_idx,
  output logic [2:0]      eew_log,
  output logic [2:0]      emul_log,
  output logic [RW-1:0]   reg_num,
  output logic [VLOG-1:0] bit_off,
  output logic            illegal
);

  logic [1:0]    sew_q;
  logic [2:0]    lmul_q;
  logic          dbl;
  logic [3:0]    emul_w;
  logic [PW-1:0] pos, pos_end, grp_bits;
  logic [RW:0]   grp_regs, grp_top;
  logic          bad_code, bad_size, bad_align, bad_fit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sew_q  <= 2'd0;
      lmul_q <= 3'd0;
    end else if (cfg_we) begin
      sew_q  <= cfg_sew;
      lmul_q <= cfg_lmul;
    end

  assign dbl      = (op_role == 2'd1) || (op_role == 2'd2);
  assign eew_log  = {1'b0, sew_q} + {2'b00, dbl};
  assign emul_w   = {1'b0, lmul_q} + {3'b000, dbl};
  assign emul_log = emul_w[2:0];

  assign pos      = PW'(op_idx) << (eew_log + 3'd3);
  assign pos_end  = pos + (PW'(8) << eew_log);
  assign grp_bits = PW'(VLEN) << emul_w;
  assign grp_regs = (RW+1)'(1) << emul_w;
  assign grp_top  = {1'b0, op_base} + grp_regs;

  assign bad_code  = (op_role == 2'd3) || (lmul_q > 3'd3);
  assign bad_size  = (emul_w > 4'd3) || (eew_log > 3'd3);
  assign bad_align = ((op_base & (grp_regs[RW-1:0] - 1'b1)) != '0) || (grp_top > (RW+1)'(NREG));
  assign bad_fit   = pos_end > grp_bits;
  assign illegal   = bad_code | bad_size | bad_align | bad_fit;

  assign reg_num = op_base + RW'(pos >> VLOG);
  assign bit_off = pos[VLOG-1:0];

  p_ratio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal |-> ((eew_log - emul_log) == ({1'b0, sew_q} - lmul_q)));

  p_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal |-> (emul_log <= 3'd3) && (eew_log <= 3'd3));

  p_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal |-> ((int'(op_base) % (1 << emul_log)) == 0) &&
                 (int'(op_base) + (1 << emul_log) <= NREG));

  p_inside_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal |-> (int'(reg_num) - int'(op_base) < (1 << emul_log)) &&
                 ((int'(bit_off) % (8 << eew_log)) == 0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(sew_q) && $stable(lmul_q));

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (sew_q == $past(cfg_sew)) && (lmul_q == $past(cfg_lmul)));

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_role == 2'd3) || (lmul_q > 3'd3)) |-> illegal);

endmodule

// File: tb/vgrp_locator_bench.sv
`timescale 1ns/1ps
module vgrp_locator_bench;
  localparam int VLEN = 32;

  typedef struct {
    int    eew, emul, rg, off;
    bit    ill;
    string tag;
  } exp_t;

  logic clk = 0, rst_n = 0, cfg_we = 0;
  logic [1:0] cfg_sew = 0, op_role = 0;
  logic [2:0] cfg_lmul = 0;
  logic [4:0] op_base = 0;
  logic [7:0] op_idx = 0;
  logic [2:0] eew_log, emul_log;
  logic [4:0] reg_num, bit_off;
  logic illegal;

  int total = 0, bad = 0, m_sew = 0, m_lmul = 0;
  bit done = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  vgrp_locator u_vgrp_locator (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sew(cfg_sew), .cfg_lmul(cfg_lmul),
    .op_role(op_role), .op_base(op_base), .op_idx(op_idx), .eew_log(eew_log),
    .emul_log(emul_log), .reg_num(reg_num), .bit_off(bit_off), .illegal(illegal));

  task automatic set_cfg(input int s, input int l);
    @(negedge clk);
    cfg_sew = 2'(s); cfg_lmul = 3'(l); cfg_we = 1;
    @(negedge clk);
    cfg_we = 0; m_sew = s; m_lmul = l;
  endtask

  task automatic check(input int role, input int base, input int idx, input string tag);
    exp_t e;
    int wb, gr;
    bit dd;
    @(negedge clk);
    op_role = 2'(role); op_base = 5'(base); op_idx = 8'(idx);
    dd = (role == 1) || (role == 2);
    wb = (8 * (2 ** m_sew)) * (dd ? 2 : 1);
    gr = (2 ** m_lmul) * (dd ? 2 : 1);
    e.eew  = (m_sew + (dd ? 1 : 0)) % 8;
    e.emul = (m_lmul + (dd ? 1 : 0)) % 8;
    e.ill  = (role == 3) || (m_lmul > 3) || (gr > 8) || (wb > 64) ||
             (base % gr != 0) || (base + gr > 32) || ((idx + 1) * wb > gr * VLEN);
    e.rg   = (base + (idx * wb) / VLEN) % 32;
    e.off  = (idx * wb) % VLEN;
    e.tag  = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (illegal !== e.ill || int'(eew_log) != e.eew || int'(emul_log) != e.emul ||
            (!e.ill && (int'(reg_num) != e.rg || int'(bit_off) != e.off))) begin
          bad++;
          $display("FAIL %s: got ill=%0b eew=%0d emul=%0d reg=%0d off=%0d exp ill=%0b eew=%0d emul=%0d reg=%0d off=%0d",
                   e.tag, illegal, eew_log, emul_log, reg_num, bit_off,
                   e.ill, e.eew, e.emul, e.rg, e.off);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got hang exp finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(0, 0, 0, "R8 reset codes");
    set_cfg(1, 1);
    check(0, 2, 3, "R1 plain role");
    check(1, 4, 3, "R2 widening dest");
    check(2, 4, 3, "R2 narrowing src");
    set_cfg(2, 0);
    check(1, 6, 1, "R3 ratio widening");
    check(0, 6, 0, "R3 ratio plain");
    set_cfg(0, 3);
    check(1, 8, 0, "R4 group past 8");
    set_cfg(3, 2);
    check(1, 4, 0, "R4 width past 64");
    set_cfg(0, 2);
    check(0, 2, 0, "R5 misaligned base");
    check(0, 28, 0, "R5 top aligned group");
    check(1, 4, 0, "R5 doubled group misaligned");
    set_cfg(0, 0);
    check(0, 5, 3, "R6 byte mapping");
    set_cfg(0, 3);
    check(0, 8, 20, "R6 grouped mapping");
    check(0, 16, 31, "R7 last element in group");
    check(0, 16, 32, "R7 index past group");
    set_cfg(3, 0);
    check(0, 2, 0, "R7 wide element one reg");
    set_cfg(3, 1);
    check(0, 2, 0, "R7 wide element spans two regs");
    check(0, 2, 1, "R7 second wide element past group");
    set_cfg(1, 2);
    @(negedge clk);
    cfg_sew = 2'd3; cfg_lmul = 3'd3;
    check(0, 4, 9, "R8 ignored without strobe");
    set_cfg(0, 5);
    check(0, 0, 0, "R9 reserved group code");
    set_cfg(0, 0);
    check(3, 0, 0, "R9 reserved role");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule